// File: doc/BRIEF.md
# Serial-Load DAC Code Register

This block is the digital front end of a serial-input digital-to-analogue converter. A 12-bit code arrives one bit at a time on a serial data pin, clocked by a serial clock, while a combined select/load line is held low. When the select/load line returns high, the assembled word is committed to a holding register. The holding register drives the converter code as a 12-bit parallel output. A serial data output carries the bits falling out of the shift register, so several of these blocks can be chained: the downstream unit receives the previous word of the upstream one.

The serial pins are treated as slow inputs. They are sampled by a fast system clock through two-stage synchronizers, and their edges are detected in that domain, so the whole block runs on one clock. An active-low clear forces the shift register, the holding register and the load strobe to zero at once, with no clock edge needed. A synchronous active-high reset does the same at power-up and also returns the synchronizers to their idle levels. A one-cycle strobe marks every update of the holding register.

Top module: `dac_serial_front`

## Requirements
- R1: While `rst` is high, `dac_code` is 0, `sd_out` is 0 and `load_pulse` is 0 after the next system clock edge.
- R2: On a rising edge of `sck_in` while `sel_ld_in` is low, the shift register shifts toward its most significant end and takes `sd_in` into bit 0. The first bit sent therefore ends up in bit 11 of a 12-bit word (most significant bit first).
- R3: Rising edges of `sck_in` while `sel_ld_in` is high leave the shift register unchanged.
- R4: A low-to-high transition of `sel_ld_in` copies the shift register into `dac_code`. `dac_code` holds its value at all other times, except under clear or reset.
- R5: `load_pulse` is high for exactly one system clock cycle for each update of `dac_code`, in the same cycle the new code appears.
- R6: `sd_out` always equals bit 11 of the shift register. While a new word is being shifted in, it therefore presents the previous word, most significant bit first.
- R7: While `clr_n` is low, the shift register, `dac_code` and `load_pulse` are 0. Pulling `clr_n` low takes effect without waiting for a system clock edge.
- R8: The clear wins over a shift or a load that falls in the same cycle. A select/load rising edge detected while `clr_n` is low is dropped and produces no pulse.
- R9: A frame with fewer or more than 12 serial clock edges, including none, loads whatever the shift register holds at the select/load rising edge. A long frame keeps only its last 12 bits. No error is raised.
- R10: A change on `sck_in` or `sel_ld_in` that is applied before system clock edge k takes effect at edge k+2: two synchronizer stages plus one register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| clr_n | input | 1 | Asynchronous active-low clear of shift and holding registers |
| sck_in | input | 1 | Serial clock; data taken on its rising edge |
| sd_in | input | 1 | Serial data, most significant bit first |
| sel_ld_in | input | 1 | Low enables shifting; low-to-high transition loads the code |
| sd_out | output | 1 | Last stage of the shift register, for chaining |
| dac_code | output | 12 | Converter code from the holding register |
| load_pulse | output | 1 | One-cycle strobe on each holding register update |

## Verification
Every pin change on `sck_in` or `sel_ld_in` becomes visible at the third system clock edge after it is driven. That is two synchronizer edges plus the register edge, so `dac_code`, `sd_out` and `load_pulse` all move at that edge. The bench's reference model delays each sampled pin through a three-deep history queue. It compares all three outputs 5 ns after every rising clock edge, once the registers have settled and well before the next drive on the falling edge. A directed check confirms the latency by checking that the code is still unchanged at the second edge after the load edge and updated at the third. The clear is checked 3 ns after it is driven, before any clock edge, to confirm that it acts asynchronously.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

    parameter int unsigned WORD_W      = 12;
    parameter int unsigned SYNC_STAGES = 2;

    // Synchronized serial pins, carried together so they stay aligned.
    typedef struct packed {
        logic sel_ld;
        logic sck;
        logic sd;
    } ser_pins_t;

    localparam int unsigned PINS_W = $bits(ser_pins_t);

    // Idle levels: select/load high, clock low, data low.
    localparam ser_pins_t PINS_IDLE = '{sel_ld: 1'b1, sck: 1'b0, sd: 1'b0};

    // Edge-detected pair: index 1 = select/load, index 0 = serial clock.
    typedef struct packed {
        logic sel_ld;
        logic sck;
    } edge_pair_t;

    localparam edge_pair_t EDGE_IDLE = '{sel_ld: 1'b1, sck: 1'b0};

    function automatic logic [WORD_W-1:0] shift_msb_first(
        input logic [WORD_W-1:0] cur,
        input logic              bit_in
    );
        return {cur[WORD_W-2:0], bit_in};
    endfunction

endpackage

// File: rtl/dsf_sync.sv
module dsf_sync #(
    parameter int unsigned        W       = 3,
    parameter int unsigned        STAGES  = 2,
    parameter logic [W-1:0]       RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= RST_VAL;
                else     chain[0] <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
                end else begin
                    chain[0] <= din;
                    for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/dsf_edge.sv
module dsf_edge #(
    parameter int unsigned  W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] level,
    output logic [W-1:0] rise
);

    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= level;
    end

    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            assign rise[g] = level[g] & ~prev[g];
        end
    endgenerate

endmodule

// File: rtl/dsf_shift.sv
module dsf_shift
    import dsf_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word,
    output logic         tail
);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)        word <= '0;
        else if (rst)      word <= '0;
        else if (shift_en) word <= {word[W-2:0], bit_in};
    end

    assign tail = word[W-1];

    // R2: a shift moves toward the MSB end and takes the new bit at bit 0
    p_shift_in_r2: assert property (@(posedge clk) disable iff (rst || !clr_n)
        shift_en |=> (word[0] == $past(bit_in)) && (word[W-1:1] == $past(word[W-2:0])));

    // R3: no shift enable, no change
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst || !clr_n)
        !shift_en |=> $stable(word));

endmodule

// File: rtl/dsf_hold.sv
module dsf_hold
    import dsf_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_n,
    input  logic         load_en,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] code,
    output logic         strobe
);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            code   <= '0;
            strobe <= 1'b0;
        end else if (rst) begin
            code   <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= load_en;
            if (load_en) code <= word_in;
        end
    end

    // R4: a load copies the shift word
    p_copy_r4: assert property (@(posedge clk) disable iff (rst || !clr_n)
        load_en |=> code == $past(word_in));

    // R4: without a load the code holds
    p_keep_r4: assert property (@(posedge clk) disable iff (rst || !clr_n)
        !load_en |=> $stable(code));

    // R5: strobe follows each load and lasts one cycle
    p_strobe_r5: assert property (@(posedge clk) disable iff (rst || !clr_n)
        load_en |=> strobe);

    p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst || !clr_n)
        strobe |=> !strobe);

endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
    import dsf_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned STAGES = SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_n,
    input  logic              sck_in,
    input  logic              sd_in,
    input  logic              sel_ld_in,
    output logic              sd_out,
    output logic [DATA_W-1:0] dac_code,
    output logic              load_pulse
);

    ser_pins_t   pins_raw;
    ser_pins_t   pins_sync;
    edge_pair_t  lvl_pair;
    edge_pair_t  rise_pair;
    logic        shift_en;
    logic        load_en;
    logic [DATA_W-1:0] shift_word;

    assign pins_raw = '{sel_ld: sel_ld_in, sck: sck_in, sd: sd_in};

    dsf_sync #(
        .W       (PINS_W),
        .STAGES  (STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pins_raw),
        .dout (pins_sync)
    );

    assign lvl_pair = '{sel_ld: pins_sync.sel_ld, sck: pins_sync.sck};

    dsf_edge #(
        .W       ($bits(edge_pair_t)),
        .RST_VAL (EDGE_IDLE)
    ) u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (lvl_pair),
        .rise  (rise_pair)
    );

    // Serial clock is gated by the select/load level; load on its rise.
    assign shift_en = rise_pair.sck & ~pins_sync.sel_ld;
    assign load_en  = rise_pair.sel_ld;

    dsf_shift #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clr_n    (clr_n),
        .shift_en (shift_en),
        .bit_in   (pins_sync.sd),
        .word     (shift_word),
        .tail     (sd_out)
    );

    dsf_hold #(.W(DATA_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .clr_n   (clr_n),
        .load_en (load_en),
        .word_in (shift_word),
        .code    (dac_code),
        .strobe  (load_pulse)
    );

    // R3: while select/load is high the shift word never moves
    p_sck_gated_r3: assert property (@(posedge clk) disable iff (rst || !clr_n)
        pins_sync.sel_ld |=> $stable(shift_word));

    // R6: serial output is the top stage of the shift word
    p_tail_r6: assert property (@(posedge clk) disable iff (rst || !clr_n)
        sd_out == shift_word[DATA_W-1]);

    // R7/R8: clear forces everything to zero and suppresses the strobe
    p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (dac_code == '0) && !sd_out && !load_pulse);

endmodule

// File: tb/sim_dac_serial_front.sv
`timescale 1ns/1ps
module sim_dac_serial_front;

    logic        clk = 1'b0;
    logic        rst;
    logic        clr_n;
    logic        sck_in;
    logic        sd_in;
    logic        sel_ld_in;
    logic        sd_out;
    logic [11:0] dac_code;
    logic        load_pulse;

    always #10 clk = ~clk;

    dac_serial_front u0 (
        .clk        (clk),
        .rst        (rst),
        .clr_n      (clr_n),
        .sck_in     (sck_in),
        .sd_in      (sd_in),
        .sel_ld_in  (sel_ld_in),
        .sd_out     (sd_out),
        .dac_code   (dac_code),
        .load_pulse (load_pulse)
    );

    int n_chk = 0;
    int n_err = 0;
    int n_pulse = 0;
    bit cmp_on = 0;
    bit finished = 0;

    // Reference model state
    logic [11:0] m_sh  = '0;
    logic [11:0] m_dac = '0;
    logic        m_pl  = 1'b0;
    logic        hs[$] = '{1'b0, 1'b0, 1'b0};
    logic        hl[$] = '{1'b1, 1'b1, 1'b1};
    logic        hd[$] = '{1'b0, 1'b0, 1'b0};

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Model: pin value history, index k = sampled k+1 edges ago
    always @(posedge clk) begin
        logic rs;
        logic rl;
        if (rst) begin
            m_sh = '0; m_dac = '0; m_pl = 1'b0;
            hs = '{1'b0, 1'b0, 1'b0};
            hl = '{1'b1, 1'b1, 1'b1};
            hd = '{1'b0, 1'b0, 1'b0};
        end else begin
            rs = hs[1] && !hs[2];
            rl = hl[1] && !hl[2];
            if (!clr_n) begin
                m_sh = '0; m_dac = '0; m_pl = 1'b0;
            end else begin
                m_pl = rl;
                if (rl) m_dac = m_sh;
                if (rs && !hl[1]) m_sh = {m_sh[10:0], hd[1]};
            end
            hs.push_front(sck_in);    void'(hs.pop_back());
            hl.push_front(sel_ld_in); void'(hl.pop_back());
            hd.push_front(sd_in);     void'(hd.pop_back());
        end
        #5;
        if (cmp_on) begin
            chk(dac_code == m_dac, "R4 code vs model", dac_code, m_dac);
            chk(sd_out == m_sh[11], "R6 serial out vs model", sd_out, m_sh[11]);
            chk(load_pulse == m_pl, "R5 strobe vs model", load_pulse, m_pl);
            if (load_pulse) n_pulse++;
        end
    end

    task automatic shift_bits(input logic [15:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            sd_in  = w[i];
            sck_in = 1'b0;
            repeat (2) @(negedge clk);
            sck_in = 1'b1;
            repeat (2) @(negedge clk);
        end
        @(negedge clk);
        sck_in = 1'b0;
    endtask

    task automatic do_load();
        @(negedge clk);
        sel_ld_in = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic frame(input logic [15:0] w, input int n);
        @(negedge clk);
        sel_ld_in = 1'b0;
        repeat (2) @(negedge clk);
        shift_bits(w, n);
        repeat (2) @(negedge clk);
        do_load();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        int snap;
        rst = 1'b1; clr_n = 1'b1; sck_in = 1'b0; sd_in = 1'b0; sel_ld_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(dac_code == 12'h000, "R1 reset code", dac_code, 0);
        chk(sd_out == 1'b0, "R1 reset sd_out", sd_out, 0);
        chk(load_pulse == 1'b0, "R1 reset strobe", load_pulse, 0);
        rst = 1'b0;
        cmp_on = 1;
        repeat (4) @(negedge clk);

        // R2: full word, MSB first
        frame(16'h0A5C, 12);
        chk(dac_code == 12'hA5C, "R2 word MSB first", dac_code, 12'hA5C);

        // R6: during next word sd_out shows previous word MSB first
        @(negedge clk);
        sel_ld_in = 1'b0;
        repeat (4) @(negedge clk);
        chk(sd_out == 1'b1, "R6 previous word bit 11", sd_out, 1);
        shift_bits(16'h0000, 1);
        repeat (4) @(negedge clk);
        chk(sd_out == 1'b0, "R6 previous word bit 10", sd_out, 0);
        shift_bits(16'h03F1, 11);
        repeat (2) @(negedge clk);

        // R10: load rise driven now, code changes at the third edge
        sel_ld_in = 1'b1;
        @(posedge clk); #6;
        chk(dac_code == 12'hA5C, "R10 edge 1 unchanged", dac_code, 12'hA5C);
        @(posedge clk); #6;
        chk(dac_code == 12'hA5C, "R10 edge 2 unchanged", dac_code, 12'hA5C);
        @(posedge clk); #6;
        chk(dac_code == 12'h3F1, "R10 edge 3 updated", dac_code, 12'h3F1);
        chk(load_pulse == 1'b1, "R5 strobe with update", load_pulse, 1);
        @(posedge clk); #6;
        chk(load_pulse == 1'b0, "R5 strobe one cycle", load_pulse, 0);
        repeat (4) @(negedge clk);

        // R3: serial clock edges with select/load high are ignored
        sd_in = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); sck_in = 1'b1;
            repeat (2) @(negedge clk); sck_in = 1'b0;
            repeat (2) @(negedge clk);
        end
        chk(sd_out == 1'b0, "R3 shift untouched while high", sd_out, 0);
        frame(16'h0000, 0);   // R9: zero-edge frame reloads the held word
        chk(dac_code == 12'h3F1, "R3 R9 empty frame reload", dac_code, 12'h3F1);

        // R9: short and long frames
        frame(16'h000A, 4);
        chk(dac_code == 12'hF1A, "R9 short frame", dac_code, 12'hF1A);
        frame(16'h2003, 14);
        chk(dac_code == 12'h003, "R9 long frame", dac_code, 12'h003);

        // R7: asynchronous clear
        frame(16'h0FFF, 12);
        chk(dac_code == 12'hFFF, "R4 all ones", dac_code, 12'hFFF);
        @(negedge clk);
        clr_n = 1'b0;
        #3;
        chk(dac_code == 12'h000, "R7 async clear code", dac_code, 0);
        chk(sd_out == 1'b0, "R7 async clear shift", sd_out, 0);
        repeat (3) @(negedge clk);
        clr_n = 1'b1;
        repeat (3) @(negedge clk);

        // R8: clear beats a load rise in the same window
        @(negedge clk);
        sel_ld_in = 1'b0;
        repeat (2) @(negedge clk);
        shift_bits(16'h05A5, 12);
        repeat (2) @(negedge clk);
        snap = n_pulse;
        clr_n = 1'b0;
        @(negedge clk);
        sel_ld_in = 1'b1;
        repeat (6) @(negedge clk);
        clr_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(dac_code == 12'h000, "R8 load dropped under clear", dac_code, 0);
        chk(n_pulse == snap, "R8 no strobe under clear", n_pulse, snap);

        frame(16'h07E2, 12);
        chk(dac_code == 12'h7E2, "R4 load after clear", dac_code, 12'h7E2);
        chk(n_pulse == 7, "R5 strobe count", n_pulse, 7);

        repeat (4) @(negedge clk);
        summary();
    end

endmodule